// File: doc/BRIEF.md
# Serial DAC Channel Loader

This block drives a group of serial digital-to-analog converters, one converter per channel. A bus-side write places a 16-bit word on a channel. The block keeps the low 12 bits of that word and sends them over a three-wire serial link to the converter: an active-low select, a serial clock and a data line. After the last bit it pulses an active-low load strobe, which moves the shifted value into the converter's output latch. The analog output therefore changes only once a whole word has arrived.

Each channel has its own serializer, so all channels can shift at the same time. The serial clock runs at the system clock divided by `CLK_DIV`. A write that arrives while its channel is busy is held in a one-word slot, and a newer write replaces it. The held word is sent directly after the transfer in progress. A per-channel busy flag covers the whole time from the write until the load pulse ends.

Timing below uses the following convention. Cycle n means the values visible after the n-th rising clock edge, where edge 1 is the edge that samples the write. The figures are for the default `CLK_DIV` = 4 and 12 data bits.

Top module: `dac_serial_loader`

## Requirements
- R1: A write to channel c (wr_en[c] high at a rising edge) drives dac_sel_n[c] low in cycle 2. It is still high in cycle 1.
- R2: Only wr_data[11:0] is transmitted. Bits 15:12 have no effect on the serial data.
- R3: Each frame carries exactly 12 bits, sampled on the rising serial clock edges, most significant bit (bit 11) first and bit 0 last.
- R4: While select is low during the bit phase, the serial clock has a period of CLK_DIV cycles. It is low for the first half of each bit period and high for the second half. The data line changes only while the clock is low.
- R5: Select stays low, with the clock low, for one more serial period after the last bit period, and then returns high (high in cycle 54). The serial clock is low whenever select is high.
- R6: The load strobe goes low only after all 12 bits, only while select is high, and stays low for exactly CLK_DIV cycles (cycles 54 to 57).
- R7: Channels run independently. A write to one channel starts its frame on schedule while another channel is in mid-transfer.
- R8: A write to a busy channel is held. A later write replaces the held word, so only the newest held word is sent. Its select falls in the cycle right after the previous load pulse ends.
- R9: busy[c] is high from cycle 2 through the last load cycle (56 cycles for one frame) and low afterwards if nothing is held.
- R10: While reset is asserted and after it is released, every channel shows idle lines: select high, load high, clock low, data low and busy low. A reset in mid-transfer aborts the frame without a load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | CH_COUNT | Per-channel write strobe |
| wr_data | input | WORD_W | Word written to every strobed channel |
| dac_sel_n | output | CH_COUNT | Active-low converter select per channel |
| dac_sclk | output | CH_COUNT | Serial clock per channel |
| dac_sdata | output | CH_COUNT | Serial data per channel |
| dac_load_n | output | CH_COUNT | Active-low output-latch load strobe per channel |
| busy | output | CH_COUNT | Channel has a transfer in progress or held |

## Verification
A bit counter that is off by one shows up at the load strobe of the same frame, about 13 serial periods after the write. The frame then has the wrong number of clock rises or the wrong received value. A wrong phase or state shows up within one serial period: the clock runs while select is high, data moves while the clock is high, or load overlaps select. A held word that is lost or not overwritten shows up one frame later, as a missing or extra frame in the per-channel expected stream, or as a gap between the load pulse and the next select.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    localparam int unsigned DEF_CH_COUNT = 4;
    localparam int unsigned DEF_WORD_W   = 16;
    localparam int unsigned DEF_BITS     = 12;
    localparam int unsigned DEF_CLK_DIV  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2,
        ST_LOAD  = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic sdata;
        logic load_n;
        logic busy;
    } dac_lines_t;

    function automatic dac_lines_t lines_idle();
        dac_lines_t l;
        l.sel_n  = 1'b1;
        l.sclk   = 1'b0;
        l.sdata  = 1'b0;
        l.load_n = 1'b1;
        l.busy   = 1'b0;
        return l;
    endfunction

endpackage

// File: rtl/dsl_pending.sv
module dsl_pending #(
    parameter int unsigned WORD_W    = dsl_pkg::DEF_WORD_W,
    parameter int unsigned DATA_BITS = dsl_pkg::DEF_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 take,
    output logic                 avail,
    output logic [DATA_BITS-1:0] val
);

    logic                 held_v;
    logic [DATA_BITS-1:0] held_d;
    logic                 unused_hi;

    // Upper bits of the written word carry no transfer data
    assign unused_hi = ^wdata[WORD_W-1:DATA_BITS];

    // A write in the same cycle is the newest word and wins over the held one
    assign avail = wr | held_v;
    assign val   = wr ? wdata[DATA_BITS-1:0] : held_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held_d <= '0;
        end else if (take) begin
            held_v <= 1'b0;
        end else if (wr) begin
            held_v <= 1'b1;
            held_d <= wdata[DATA_BITS-1:0];
        end
    end

endmodule

// File: rtl/dsl_engine.sv
module dsl_engine
    import dsl_pkg::*;
#(
    parameter int unsigned DATA_BITS = DEF_BITS,
    parameter int unsigned CLK_DIV   = DEF_CLK_DIV
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 avail,
    input  logic [DATA_BITS-1:0] val,
    output logic                 take,
    output dac_lines_t           lines
);

    localparam int unsigned PH_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int unsigned BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    eng_state_e           state;
    logic [PH_W-1:0]      ph;
    logic [BIT_W-1:0]     bitn;
    logic [DATA_BITS-1:0] shreg;
    logic                 last_ph;

    assign last_ph = (ph == PH_LAST);

    // New words are accepted from idle, or at the very end of a load pulse
    assign take = avail && ((state == ST_IDLE) ||
                            ((state == ST_LOAD) && last_ph));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ph    <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ph   <= '0;
                    bitn <= '0;
                    if (take) begin
                        state <= ST_SHIFT;
                        shreg <= val;
                    end
                end
                ST_SHIFT: begin
                    if (last_ph) begin
                        ph <= '0;
                        if (bitn == BIT_LAST) begin
                            state <= ST_TRAIL;
                            bitn  <= '0;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            shreg <= {shreg[DATA_BITS-2:0], 1'b0};
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (last_ph) begin
                        ph    <= '0;
                        state <= ST_LOAD;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (last_ph) begin
                        ph <= '0;
                        if (take) begin
                            state <= ST_SHIFT;
                            shreg <= val;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line decode from the state; registered downstream
    always_comb begin
        lines        = lines_idle();
        lines.busy   = (state != ST_IDLE);
        lines.sel_n  = !((state == ST_SHIFT) || (state == ST_TRAIL));
        lines.sclk   = (state == ST_SHIFT) && (ph >= PH_HALF);
        lines.sdata  = (state == ST_SHIFT) && shreg[DATA_BITS-1];
        lines.load_n = (state != ST_LOAD);
    end

endmodule

// File: rtl/dsl_line_reg.sv
module dsl_line_reg
    import dsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dac_lines_t d,
    output dac_lines_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= lines_idle();
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
    import dsl_pkg::*;
#(
    parameter int unsigned CH_COUNT  = DEF_CH_COUNT,
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned DATA_BITS = DEF_BITS,
    parameter int unsigned CLK_DIV   = DEF_CLK_DIV
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CH_COUNT-1:0] wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [CH_COUNT-1:0] dac_sel_n,
    output logic [CH_COUNT-1:0] dac_sclk,
    output logic [CH_COUNT-1:0] dac_sdata,
    output logic [CH_COUNT-1:0] dac_load_n,
    output logic [CH_COUNT-1:0] busy
);

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        logic                 avail;
        logic                 take;
        logic [DATA_BITS-1:0] val;
        dac_lines_t           raw;
        dac_lines_t           reg_q;

        dsl_pending #(
            .WORD_W   (WORD_W),
            .DATA_BITS(DATA_BITS)
        ) u_pend (
            .clk  (clk),
            .rst  (rst),
            .wr   (wr_en[c]),
            .wdata(wr_data),
            .take (take),
            .avail(avail),
            .val  (val)
        );

        dsl_engine #(
            .DATA_BITS(DATA_BITS),
            .CLK_DIV  (CLK_DIV)
        ) u_eng (
            .clk  (clk),
            .rst  (rst),
            .avail(avail),
            .val  (val),
            .take (take),
            .lines(raw)
        );

        dsl_line_reg u_oreg (
            .clk(clk),
            .rst(rst),
            .d  (raw),
            .q  (reg_q)
        );

        assign dac_sel_n[c]  = reg_q.sel_n;
        assign dac_sclk[c]   = reg_q.sclk;
        assign dac_sdata[c]  = reg_q.sdata;
        assign dac_load_n[c] = reg_q.load_n;
        assign busy[c]       = reg_q.busy;
    end

endmodule

// File: rtl/dsl_checker.sv
module dsl_checker #(
    parameter int unsigned CH_COUNT  = dsl_pkg::DEF_CH_COUNT,
    parameter int unsigned DATA_BITS = dsl_pkg::DEF_BITS
) (
    input logic                clk,
    input logic                rst,
    input logic [CH_COUNT-1:0] dac_sel_n,
    input logic [CH_COUNT-1:0] dac_sclk,
    input logic [CH_COUNT-1:0] dac_sdata,
    input logic [CH_COUNT-1:0] dac_load_n,
    input logic [CH_COUNT-1:0] busy
);

    localparam int unsigned CNT_W = $clog2(DATA_BITS + 2);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (dac_sel_n == '1 && dac_load_n == '1 && dac_sclk == '0 && busy == '0)); // R10

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_chk
        logic [CNT_W-1:0] rises;
        logic             sclk_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rises  <= '0;
                sclk_q <= 1'b0;
            end else begin
                sclk_q <= dac_sclk[c];
                if (dac_sel_n[c]) begin
                    rises <= '0;
                end else if (dac_sclk[c] && !sclk_q) begin
                    rises <= rises + 1'b1;
                end
            end
        end

        AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
            dac_sel_n[c] |-> !dac_sclk[c]); // R5

        AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
            (dac_sclk[c] && $past(dac_sclk[c])) |-> $stable(dac_sdata[c])); // R4

        AST_LOAD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
            !dac_load_n[c] |-> dac_sel_n[c]); // R6

        AST_LOAD_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
            $fell(dac_load_n[c]) |=> !dac_load_n[c]); // R6

        AST_FRAME_BIT_COUNT: assert property (@(posedge clk) disable iff (rst)
            $rose(dac_sel_n[c]) |-> (rises == CNT_W'(DATA_BITS))); // R3

        AST_LOAD_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
            !dac_load_n[c] |-> busy[c]); // R9

        AST_SELECT_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
            !dac_sel_n[c] |-> busy[c]); // R1
    end

endmodule

bind dac_serial_loader dsl_checker #(
    .CH_COUNT (CH_COUNT),
    .DATA_BITS(DATA_BITS)
) u_dsl_chk (
    .clk       (clk),
    .rst       (rst),
    .dac_sel_n (dac_sel_n),
    .dac_sclk  (dac_sclk),
    .dac_sdata (dac_sdata),
    .dac_load_n(dac_load_n),
    .busy      (busy)
);

// File: tb/tb_dac_serial_loader.sv
module tb_dac_serial_loader;

    localparam int CLK_PERIOD = 10;
    localparam int CH  = 4;
    localparam int WW  = 16;
    localparam int NB  = 12;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CH-1:0] wr_en = '0;
    logic [WW-1:0] wr_data = '0;
    logic [CH-1:0] dac_sel_n, dac_sclk, dac_sdata, dac_load_n, busy;

    int n_chk = 0;
    int n_bad = 0;

    logic [NB-1:0] exp_q [CH][$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_loader #(
        .CH_COUNT (CH),
        .WORD_W   (WW),
        .DATA_BITS(NB),
        .CLK_DIV  (DIV)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .dac_sel_n (dac_sel_n),
        .dac_sclk  (dac_sclk),
        .dac_sdata (dac_sdata),
        .dac_load_n(dac_load_n),
        .busy      (busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: one-cycle write, expected words pushed into the scoreboard.
    // Returns at the falling edge where cycle 1 values are visible.
    task automatic wr(input logic [CH-1:0] m, input logic [WW-1:0] d);
        @(negedge clk);
        wr_en   = m;
        wr_data = d;
        for (int c = 0; c < CH; c++) if (m[c]) exp_q[c].push_back(d[NB-1:0]);
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy != '0);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: decodes frames on rising serial clock edges, compares at load
    logic [CH-1:0] p_sclk, p_sel, p_load, p_sdata;
    logic [NB-1:0] acc [CH];
    int            nb  [CH];

    always @(negedge clk) begin
        if (rst) begin
            p_sclk = '0; p_sel = '1; p_load = '1; p_sdata = '0;
            for (int c = 0; c < CH; c++) begin acc[c] = '0; nb[c] = 0; end
        end else begin
            for (int c = 0; c < CH; c++) begin
                if (p_sel[c] && !dac_sel_n[c]) begin acc[c] = '0; nb[c] = 0; end
                if (!p_sclk[c] && dac_sclk[c] && !dac_sel_n[c]) begin
                    acc[c] = {acc[c][NB-2:0], dac_sdata[c]};
                    nb[c]++;
                end
                if (p_sclk[c] && dac_sclk[c])
                    chk("R4 data steady while clock high", 32'(dac_sdata[c]), 32'(p_sdata[c]));
                if (p_load[c] && !dac_load_n[c]) begin
                    chk("R3 bits per frame", 32'(nb[c]), 32'(NB));
                    if (exp_q[c].size() == 0) begin
                        chk("R2 unexpected frame", 32'(acc[c]), 32'hFFFF_FFFF);
                    end else begin
                        logic [NB-1:0] e;
                        e = exp_q[c].pop_front();
                        chk("R2 R3 frame value MSB first", 32'(acc[c]), 32'(e));
                    end
                end
            end
            p_sclk = dac_sclk; p_sel = dac_sel_n; p_load = dac_load_n; p_sdata = dac_sdata;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        int busy_cnt;
        // Reset state
        repeat (3) @(negedge clk);
        chk("R10 reset select", 32'(dac_sel_n), 32'hF);
        chk("R10 reset load", 32'(dac_load_n), 32'hF);
        chk("R10 reset clock/data", 32'({dac_sclk, dac_sdata}), 32'h0);
        chk("R10 reset busy", 32'(busy), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Frame timing on channel 0; top nibble set to show it is dropped
        busy_cnt = 0;
        wr(4'b0001, 16'hFA5C);
        for (int n = 1; n <= 60; n++) begin
            if (n > 1) @(negedge clk);
            if (busy[0]) busy_cnt++;
            if (n == 1) chk("R1 select still high in cycle 1", 32'(dac_sel_n[0]), 32'h1);
            if (n == 2) begin
                chk("R1 select low in cycle 2", 32'(dac_sel_n[0]), 32'h0);
                chk("R9 busy up in cycle 2", 32'(busy[0]), 32'h1);
                chk("R4 clock low first half", 32'(dac_sclk[0]), 32'h0);
            end
            if (n == 4) chk("R4 clock high second half", 32'(dac_sclk[0]), 32'h1);
            if (n == 6) chk("R4 clock low next period", 32'(dac_sclk[0]), 32'h0);
            if (n == 52) chk("R5 trailing period clock low", 32'({dac_sel_n[0], dac_sclk[0]}), 32'h0);
            if (n == 53) chk("R5 select low through trail", 32'(dac_sel_n[0]), 32'h0);
            if (n == 54) begin
                chk("R5 select high in cycle 54", 32'(dac_sel_n[0]), 32'h1);
                chk("R6 load low in cycle 54", 32'(dac_load_n[0]), 32'h0);
            end
            if (n == 57) chk("R6 load low in cycle 57", 32'(dac_load_n[0]), 32'h0);
            if (n == 58) begin
                chk("R6 load high in cycle 58", 32'(dac_load_n[0]), 32'h1);
                chk("R9 busy low in cycle 58", 32'(busy[0]), 32'h0);
            end
        end
        chk("R9 busy cycle count", 32'(busy_cnt), 32'd56);

        // Value patterns
        wr(4'b0001, 16'h0000); wait_idle();
        wr(4'b0001, 16'h0FFF); wait_idle();
        wr(4'b0001, 16'h7800); wait_idle();
        wr(4'b0001, 16'hC001); wait_idle();

        // All channels at once (R7)
        wr(4'b1111, 16'h13C6); wait_idle();

        // Staggered: channel 3 starts while channel 2 shifts (R7)
        wr(4'b0100, 16'h0123);
        repeat (3) @(negedge clk);
        wr(4'b1000, 16'h5EDC);
        chk("R7 ch3 select high in cycle 1", 32'(dac_sel_n[3]), 32'h1);
        @(negedge clk);
        chk("R7 ch3 select low in cycle 2", 32'(dac_sel_n[3]), 32'h0);
        chk("R7 ch2 still busy", 32'(busy[2]), 32'h1);
        wait_idle();

        // Held words on channel 1: 0x222 replaced by 0x333 (R8)
        wr(4'b0010, 16'h0111);
        repeat (10) @(negedge clk);
        wr(4'b0010, 16'h0222);
        repeat (5) @(negedge clk);
        wr(4'b0010, 16'h0333);
        void'(exp_q[1].pop_back());
        void'(exp_q[1].pop_back());
        exp_q[1].push_back(12'h333);
        while (dac_load_n[1]) @(negedge clk);
        while (!dac_load_n[1]) @(negedge clk);
        chk("R8 held word select right after load", 32'(dac_sel_n[1]), 32'h0);
        chk("R8 busy continuous", 32'(busy[1]), 32'h1);
        wait_idle();

        // Reset in mid-transfer (R10)
        wr(4'b0001, 16'h0555);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        exp_q[0].delete();
        repeat (2) @(negedge clk);
        chk("R10 abort select high", 32'(dac_sel_n[0]), 32'h1);
        chk("R10 abort load high", 32'(dac_load_n[0]), 32'h1);
        chk("R10 abort busy low", 32'(busy[0]), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        wr(4'b0001, 16'h90F0); wait_idle();

        for (int c = 0; c < CH; c++)
            chk("R8 R2 all expected frames delivered", 32'(exp_q[c].size()), 32'h0);

        summary();
        $finish;
    end

endmodule